// File: doc/BRIEF.md
# Configurable UART with Flow Control

This block is a full-duplex asynchronous serial transceiver. Software sets the frame format through a mode register and a control register. A frame carries 7, 8 or 9 data bits, an optional odd or even parity bit, and one or two stop bits. Transmit data is written into a holding register and shifted out on `txd`. Each complete received frame lands in a receive holding register. Status bits report the state of both holding registers and flag framing, parity and overrun errors.

The bit timing comes from a clock source followed by an (n+1) divider and a fixed divide-by-16 oversampling stage. The clock source is either one of four internally prescaled versions of `clk` or the rising edges of an external clock pin. A single handshake pin has three possible uses:
- a clear-to-send input that gates the start of each transmit frame;
- a ready-to-receive output that tracks the receive holding register;
- unused, with the pin released.

Top module: `uart_flowctl`

## Requirements
- R1: After reset `txd` is high, `hs_oe` is 0, `tx_empty` is 1, `rx_full` is 0, and the status word (address 5) reads 1. Status bits are: [0] transmit holding register empty, [1] transmitter busy, [2] receive holding full, [3] framing error, [4] parity error, [5] overrun.
- R2: The format field mode[2:0] selects the data length: 3'b100 gives 7 bits, 3'b101 gives 8 bits, 3'b110 gives 9 bits. With any other code the transmitter holds `txd` high and keeps pending data, and the receiver ignores the line.
- R3: A transmit frame is one low start bit, then the data LSB first, then the parity bit if enabled, then high stop bits. mode[4]=1 gives two stop bits and 0 gives one. A byte written while a frame is in flight is sent right after that frame's last stop bit.
- R4: mode[6]=1 inserts a parity bit. mode[5]=1 gives even parity (the count of ones over data and parity is even). mode[5]=0 gives odd parity.
- R5: With mode[3]=0, one bit lasts (n+1)*16*2^s cycles of `clk`, where n is the 8-bit value at address 2 and s is ctrl[1:0]. With mode[3]=1, one bit lasts (n+1)*16 rising edges of `ext_clk`.
- R6: The receiver detects a low start bit, confirms it at the 8th oversample tick, and samples every later bit at mid-bit. A complete frame sets `rx_full`. Reading address 4 with `rd_en` returns the data and clears `rx_full`.
- R7: A low first stop bit sets the framing-error status bit for the stored frame.
- R8: A received parity bit that does not match the selected parity sets the parity-error status bit for the stored frame.
- R9: A frame that completes while the receive holding register is full is dropped, the old data is kept, and the overrun bit is set. Reading address 4 clears the overrun bit.
- R10: With ctrl[3]=0 and ctrl[2]=0, `hs_in` is an active-low clear-to-send input. While it is high, no new frame starts. Raising it during a frame lets that frame finish.
- R11: With ctrl[3]=0 and ctrl[2]=1, `hs_oe` is 1. `hs_out` is low while the receive holding register is empty, and high from frame reception until that register is read.
- R12: With ctrl[3]=1, handshaking is off: `hs_oe` is 0 and `hs_in` has no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 4) |
| addr | input | 3 | Register address: 0 mode, 1 control, 2 divider, 3 transmit data, 4 receive data, 5 status |
| wdata | input | 9 | Write data |
| rdata | output | 9 | Read data for `addr` |
| ext_clk | input | 1 | External bit-rate clock source |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| hs_in | input | 1 | Handshake pin input (clear-to-send, active low) |
| hs_out | output | 1 | Handshake pin output (ready-to-receive, active low) |
| hs_oe | output | 1 | Handshake pin output enable |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive holding register full |

## Verification
The hardest case to reach from the ports is a clear-to-send deassertion inside a running frame. The stimulus has to watch `txd` for the falling start edge, raise `hs_in` some bit times later, and then confirm two things: the frame still decodes completely, and the next queued byte stays held until `hs_in` falls again. A forked decoder and edge watcher do this. The framing-error case is also hard to reach without a false restart. The bench holds the stop bit low only past the receiver's mid-bit sample point and then returns the line high, so the receiver's next start confirmation finds the line idle.

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
  parameter int BRG_W = 8,
  parameter int PRE_W = 3
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [8:0] wdata,
  output logic [8:0] rdata,
  input  logic       ext_clk,
  input  logic       rxd,
  output logic       txd,
  input  logic       hs_in,
  output logic       hs_out,
  output logic       hs_oe,
  output logic       tx_empty,
  output logic       rx_full
);
  localparam int FW = 13;
  localparam logic [2:0] F7 = 3'b100, F8 = 3'b101, F9 = 3'b110;
  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_BRG = 3'd2,
                         A_TX = 3'd3, A_RX = 3'd4, A_STAT = 3'd5;

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_e;

  logic [6:0]       mode_q;
  logic [3:0]       ctrl_q;
  logic [BRG_W-1:0] brg_q, bcnt_q;
  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [2:0]       ext_s;
  logic [1:0]       cts_s, rx_s;

  logic [2:0] fmt;
  logic       fmt_ok, ext_sel, two_stop, par_even, par_en, hs_dir, hs_off;
  logic [3:0] dlen;
  logic [8:0] dmask;

  assign fmt      = mode_q[2:0];
  assign ext_sel  = mode_q[3];
  assign two_stop = mode_q[4];
  assign par_even = mode_q[5];
  assign par_en   = mode_q[6];
  assign hs_dir   = ctrl_q[2];
  assign hs_off   = ctrl_q[3];
  assign fmt_ok   = (fmt == F7) || (fmt == F8) || (fmt == F9);
  assign dlen     = (fmt == F7) ? 4'd7 : (fmt == F9) ? 4'd9 : 4'd8;
  assign dmask    = (fmt == F7) ? 9'h07F : (fmt == F9) ? 9'h1FF : 9'h0FF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= 4'b1000;
      brg_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE: mode_q <= wdata[6:0];
        A_CTRL: ctrl_q <= wdata[3:0];
        A_BRG:  brg_q  <= wdata[BRG_W-1:0];
        default: ;
      endcase
    end
  end

  // clock chain: source select, (n+1) divider, oversample tick
  logic src_tick, os_tick;
  assign pre_mask = PRE_W'((1 << ctrl_q[1:0]) - 1);
  assign src_tick = ext_sel ? (ext_s[1] & ~ext_s[2]) : ((pre_q & pre_mask) == pre_mask);
  assign os_tick  = src_tick && (bcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      bcnt_q <= '0;
      ext_s  <= '0;
      cts_s  <= 2'b11;
      rx_s   <= 2'b11;
    end else begin
      pre_q <= pre_q + 1'b1;
      ext_s <= {ext_s[1:0], ext_clk};
      cts_s <= {cts_s[0], hs_in};
      rx_s  <= {rx_s[0], rxd};
      if (src_tick) bcnt_q <= (bcnt_q == '0) ? brg_q : bcnt_q - 1'b1;
    end
  end

  // transmitter
  logic [8:0]    txh_q, dm;
  logic          txh_full, tx_busy, cts_ok, tx_start, pbit;
  logic [FW-1:0] tsh_q, frame;
  logic [3:0]    tleft_q, tos_q, nb;

  assign cts_ok   = hs_off | hs_dir | ~cts_s[1];
  assign tx_start = fmt_ok && !tx_busy && txh_full && cts_ok;
  assign nb       = 4'd2 + dlen + {3'b0, par_en} + {3'b0, two_stop};

  always_comb begin
    dm    = txh_q & dmask;
    pbit  = ^dm ^ ~par_even;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(dlen)) frame[i+1] = dm[i];
    if (par_en) frame[dlen + 4'd1] = pbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txh_q    <= '0;
      txh_full <= 1'b0;
      tx_busy  <= 1'b0;
      tsh_q    <= '1;
      tleft_q  <= '0;
      tos_q    <= '0;
    end else begin
      if (!fmt_ok) begin
        tx_busy <= 1'b0;
      end else if (tx_start) begin
        tsh_q    <= frame;
        tleft_q  <= nb;
        tos_q    <= '0;
        tx_busy  <= 1'b1;
        txh_full <= 1'b0;
      end else if (tx_busy && os_tick) begin
        if (tos_q == 4'd15) begin
          tos_q   <= '0;
          tsh_q   <= {1'b1, tsh_q[FW-1:1]};
          tleft_q <= tleft_q - 1'b1;
          if (tleft_q == 4'd1) tx_busy <= 1'b0;
        end else begin
          tos_q <= tos_q + 1'b1;
        end
      end
      if (wr_en && addr == A_TX) begin
        txh_q    <= wdata;
        txh_full <= 1'b1;
      end
    end
  end

  assign txd      = !tx_busy | tsh_q[0];
  assign tx_empty = !txh_full;

  // receiver
  rx_st_e     rst_q;
  logic [3:0] ros_q, ridx_q;
  logic [8:0] rbuf_q, rdat_q;
  logic       rpar_q, fe_q, pe_q, oe_q, rxs, rd_hit, rx_done;

  assign rxs     = rx_s[1];
  assign rd_hit  = rd_en && addr == A_RX;
  assign rx_done = (rst_q == R_BITS) && os_tick && (ros_q == 4'd15) &&
                   (ridx_q == dlen + {3'b0, par_en});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= R_IDLE;
      ros_q   <= '0;
      ridx_q  <= '0;
      rbuf_q  <= '0;
      rpar_q  <= 1'b0;
      rdat_q  <= '0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      if (rd_hit) begin
        rx_full <= 1'b0;
        oe_q    <= 1'b0;
      end
      if (!fmt_ok) begin
        rst_q <= R_IDLE;
      end else if (os_tick) begin
        case (rst_q)
          R_IDLE: if (!rxs) begin
            rst_q <= R_START;
            ros_q <= '0;
          end
          R_START: if (ros_q == 4'd6) begin
            if (!rxs) begin
              rst_q  <= R_BITS;
              ros_q  <= '0;
              ridx_q <= '0;
              rbuf_q <= '0;
              rpar_q <= 1'b0;
            end else begin
              rst_q <= R_IDLE;
            end
          end else begin
            ros_q <= ros_q + 1'b1;
          end
          R_BITS: if (ros_q == 4'd15) begin
            ros_q  <= '0;
            ridx_q <= ridx_q + 1'b1;
            if (ridx_q < dlen) rbuf_q[ridx_q] <= rxs;
            else if (par_en && ridx_q == dlen) rpar_q <= rxs;
            if (rx_done) begin
              rst_q <= R_IDLE;
              if (rx_full && !rd_hit) begin
                oe_q <= 1'b1;
              end else begin
                rdat_q  <= rbuf_q;
                fe_q    <= !rxs;
                pe_q    <= par_en && ((^rbuf_q ^ rpar_q) == par_even);
                rx_full <= 1'b1;
              end
            end
          end else begin
            ros_q <= ros_q + 1'b1;
          end
          default: rst_q <= R_IDLE;
        endcase
      end
    end
  end

  // handshake pin
  assign hs_oe  = hs_dir & ~hs_off;
  assign hs_out = hs_oe ? rx_full : 1'b1;

  always_comb begin
    case (addr)
      A_MODE:  rdata = {2'b0, mode_q};
      A_CTRL:  rdata = {5'b0, ctrl_q};
      A_BRG:   rdata = 9'(brg_q);
      A_RX:    rdata = rdat_q;
      A_STAT:  rdata = {3'b0, oe_q, pe_q, fe_q, rx_full, tx_busy, !txh_full};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_flowctl_chk.sv
module uart_flowctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic       txd,
  input logic       hs_out,
  input logic       hs_oe,
  input logic       fmt_ok,
  input logic       tx_busy,
  input logic       cts_ok,
  input logic       rx_done,
  input logic       rx_full,
  input logic       oe_q
);
  // R2
  bad_fmt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_ok |=> (txd && !tx_busy));

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  // R10
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !cts_ok) |=> !tx_busy);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !(rd_en && addr == 3'd4)) |=> oe_q);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd4 && !rx_done) |=> !rx_full);

  // R11
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_oe && rx_done && !rx_full && $stable(hs_oe)) |=> (hs_out || !hs_oe));
endmodule

bind uart_flowctl uart_flowctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .txd(txd),
  .hs_out(hs_out), .hs_oe(hs_oe), .fmt_ok(fmt_ok), .tx_busy(tx_busy),
  .cts_ok(cts_ok), .rx_done(rx_done), .rx_full(rx_full), .oe_q(oe_q)
);

// File: tb/test_uart_flowctl.sv
`timescale 1ns/1ps
module test_uart_flowctl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [8:0] wdata = '0, rdata;
  logic       ext_clk, rxd = 1'b1, txd, hs_in = 1'b0, hs_out, hs_oe, tx_empty, rx_full;
  logic [1:0] ediv = '0;
  int checks = 0, errors = 0, bitclk = 16;
  bit done = 0;

  uart_flowctl i_uart_flowctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .rxd(rxd), .txd(txd),
    .hs_in(hs_in), .hs_out(hs_out), .hs_oe(hs_oe), .tx_empty(tx_empty), .rx_full(rx_full)
  );

  always #5 clk = ~clk;
  always @(negedge clk) ediv <= ediv + 1'b1;
  assign ext_clk = ediv[1];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [8:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [8:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic cfg(input logic [6:0] m, input logic [3:0] c, input logic [7:0] n);
    wr(3'd0, {2'b0, m}); wr(3'd1, {5'b0, c}); wr(3'd2, {1'b0, n});
  endtask

  function automatic logic pb(input logic [8:0] d, input int nd, input bit even);
    logic x = 1'b0;
    for (int i = 0; i < nd; i++) x ^= d[i];
    return even ? x : ~x;
  endfunction

  task automatic get_tx(input int nd, input bit pen, input int nst,
                        output logic [8:0] d, output logic p, output logic sok, output bit ok);
    ok = 0; d = '0; p = 1'b1; sok = 1'b1;
    for (int t = 0; t < 4000; t++) begin
      @(posedge clk); #1;
      if (!txd) begin ok = 1; break; end
    end
    if (!ok) return;
    repeat (bitclk/2) @(posedge clk);
    for (int i = 0; i < nd; i++) begin repeat (bitclk) @(posedge clk); #1 d[i] = txd; end
    if (pen) begin repeat (bitclk) @(posedge clk); #1 p = txd; end
    for (int s = 0; s < nst; s++) begin repeat (bitclk) @(posedge clk); #1 sok &= txd; end
  endtask

  task automatic put_rx(input logic [8:0] d, input int nd, input bit pen, input bit even,
                        input bit badpar, input bit stopv);
    logic [15:0] v = '0; int n = 1;
    for (int i = 0; i < nd; i++) begin v[n] = d[i]; n++; end
    if (pen) begin v[n] = pb(d, nd, even) ^ badpar; n++; end
    v[n] = stopv; n++;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      repeat ((i == n-1 && !stopv) ? 12 : bitclk) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2*bitclk) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    logic allhigh = 1'b1;
    for (int t = 0; t < n; t++) begin @(posedge clk); #1 allhigh &= txd; end
    chk(req, allhigh, 1'b1);
  endtask

  task automatic t_reset;
    logic [8:0] s;
    #1;
    chk("R1 txd", txd, 1'b1);
    chk("R1 hs_oe", hs_oe, 1'b0);
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 rx_full", rx_full, 1'b0);
    rd(3'd5, s);
    chk("R1 status", s, 9'h001);
  endtask

  task automatic t_tx_formats;
    logic [8:0] d; logic p, sok; bit ok;
    cfg(7'b0000101, 4'b1000, 8'd0);
    wr(3'd3, 9'h0A5);
    get_tx(8, 0, 1, d, p, sok, ok);
    chk("R3 8N1 data", d, 9'h0A5); chk("R3 8N1 stop", sok, 1'b1);
    repeat (bitclk) @(posedge clk);
    cfg(7'b1110100, 4'b1000, 8'd0);
    wr(3'd3, 9'h035); wr(3'd3, 9'h04A);
    get_tx(7, 1, 2, d, p, sok, ok);
    chk("R2 7bit data", d, 9'h035);
    chk("R4 even parity", p, pb(9'h035, 7, 1));
    chk("R3 two stops", sok, 1'b1);
    get_tx(7, 1, 2, d, p, sok, ok);
    chk("R3 queued frame", d, 9'h04A);
    chk("R4 even parity b", p, pb(9'h04A, 7, 1));
    repeat (bitclk) @(posedge clk);
    cfg(7'b1000110, 4'b1000, 8'd0);
    wr(3'd3, 9'h1C3);
    get_tx(9, 1, 1, d, p, sok, ok);
    chk("R2 9bit data", d, 9'h1C3);
    chk("R4 odd parity", p, pb(9'h1C3, 9, 0));
    repeat (bitclk) @(posedge clk);
  endtask

  task automatic t_rx;
    logic [8:0] s, v;
    cfg(7'b0000101, 4'b1000, 8'd0);
    put_rx(9'h05A, 8, 0, 0, 0, 1);
    rd(3'd5, s); chk("R6 full flag", s[2], 1'b1);
    rd(3'd4, v); chk("R6 data", v, 9'h05A);
    rd(3'd5, s); chk("R6 cleared", s[5:2], 4'b0000);
    cfg(7'b1100110, 4'b1000, 8'd0);
    put_rx(9'h155, 9, 1, 1, 0, 1);
    rd(3'd5, s); chk("R8 good parity", s[4], 1'b0);
    rd(3'd4, v); chk("R6 9bit data", v, 9'h155);
    put_rx(9'h0F0, 9, 1, 1, 1, 1);
    rd(3'd5, s); chk("R8 parity error", s[4], 1'b1);
    rd(3'd4, v);
    cfg(7'b0000101, 4'b1000, 8'd0);
    put_rx(9'h03C, 8, 0, 0, 0, 0);
    rd(3'd5, s); chk("R7 framing error", s[3], 1'b1);
    rd(3'd4, v); chk("R7 data kept", v, 9'h03C);
    put_rx(9'h011, 8, 0, 0, 0, 1);
    put_rx(9'h022, 8, 0, 0, 0, 1);
    rd(3'd5, s); chk("R9 overrun", s[5], 1'b1);
    rd(3'd4, v); chk("R9 old data", v, 9'h011);
    rd(3'd5, s); chk("R9 overrun clear", s[5], 1'b0);
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    for (int t = 0; t < 4000; t++) begin @(posedge clk); #1; if (!txd) break; end
    for (int t = 0; t < 4000; t++) begin @(posedge clk); #1; if (txd) break; end
    n = 1;
    for (int t = 0; t < 4000; t++) begin @(posedge clk); #1; if (txd) n++; else break; end
    chk(req, n, exp);
    repeat (exp*11) @(posedge clk);
  endtask

  task automatic t_rate;
    cfg(7'b0000101, 4'b1001, 8'd2);
    wr(3'd3, 9'h002);
    measure("R5 internal rate", 96);
    cfg(7'b0001101, 4'b1000, 8'd1);
    wr(3'd3, 9'h002);
    measure("R5 external rate", 128);
    cfg(7'b0000101, 4'b1000, 8'd0);
  endtask

  task automatic t_cts;
    logic [8:0] d; logic p, sok; bit ok;
    cfg(7'b0000101, 4'b0000, 8'd0);
    hs_in = 1'b1;
    wr(3'd3, 9'h03C);
    quiet(300, "R10 blocked");
    hs_in = 1'b0;
    get_tx(8, 0, 1, d, p, sok, ok);
    chk("R10 released", d, 9'h03C);
    repeat (bitclk) @(posedge clk);
    wr(3'd3, 9'h096);
    fork
      get_tx(8, 0, 1, d, p, sok, ok);
      begin wait (txd == 1'b0); repeat (40) @(posedge clk); hs_in = 1'b1; end
    join
    chk("R10 frame finishes", d, 9'h096);
    chk("R10 frame stop", sok, 1'b1);
    repeat (bitclk) @(posedge clk);
    wr(3'd3, 9'h00F);
    quiet(300, "R10 next held");
    hs_in = 1'b0;
    get_tx(8, 0, 1, d, p, sok, ok);
    chk("R10 next sent", d, 9'h00F);
    repeat (bitclk) @(posedge clk);
  endtask

  task automatic t_rts;
    logic [8:0] v;
    cfg(7'b0000101, 4'b0100, 8'd0);
    #1 chk("R11 oe", hs_oe, 1'b1);
    chk("R11 ready low", hs_out, 1'b0);
    put_rx(9'h077, 8, 0, 0, 0, 1);
    #1 chk("R11 busy high", hs_out, 1'b1);
    rd(3'd4, v);
    #1 chk("R11 low after read", hs_out, 1'b0);
  endtask

  task automatic t_hsoff;
    logic [8:0] d; logic p, sok; bit ok;
    cfg(7'b0000101, 4'b1000, 8'd0);
    hs_in = 1'b1;
    #1 chk("R12 released", hs_oe, 1'b0);
    wr(3'd3, 9'h081);
    get_tx(8, 0, 1, d, p, sok, ok);
    chk("R12 cts ignored", {ok, d}, {1'b1, 9'h081});
    hs_in = 1'b0;
    repeat (bitclk) @(posedge clk);
  endtask

  task automatic t_badfmt;
    logic [8:0] d, s; logic p, sok; bit ok;
    cfg(7'b0000000, 4'b1000, 8'd0);
    wr(3'd3, 9'h066);
    quiet(300, "R2 invalid tx idle");
    put_rx(9'h012, 8, 0, 0, 0, 1);
    rd(3'd5, s); chk("R2 invalid rx ignored", s[2], 1'b0);
    cfg(7'b0000101, 4'b1000, 8'd0);
    get_tx(8, 0, 1, d, p, sok, ok);
    chk("R2 pending kept", d, 9'h066);
    repeat (bitclk) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_formats();
    t_rx();
    t_rate();
    t_cts();
    t_rts();
    t_hsoff();
    t_badfmt();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule